// File: doc/BRIEF.md
# ALU and Condition-Code Unit

This block is the execute-stage arithmetic unit of a 16-bit processor, together with its three-bit condition-code register and the evaluation of register-indirect jumps. Each cycle it takes two operands and an operation code. The result and the jump decision are combinational. A flag update for the operation takes effect at the next rising clock edge, and only when the flag-write enable is high.

Carry is touched only by the arithmetic operations. A taken conditional jump clears the flag it tested. A shadow copy of the flags is captured on interrupt entry (`save_stb`) and written back on interrupt return (`restore_stb`). Operand forwarding, register-file access and memory are handled outside this block.

Top module: `alu_cc_unit`

## Requirements
- R1: In the flag vector, bit 0 is zero (Z), bit 1 is negative (N) and bit 2 is carry (C). After a synchronous active-low reset the flags and the shadow copy are 3'b000.
- R2: `op_sel` is encoded as follows: 0 NOP, 1 NOT, 2 INC, 3 ADD, 4 SUB, 5 AND, 6 IADD, 7 PASS, 8 SETC, 9 JZ, 10 JN, 11 JC, 12 JMP. Any other code acts as NOP. `result` is ~a for NOT, a+1 for INC, a+b for ADD and IADD (where b carries the immediate), a-b for SUB, a&b for AND and a for PASS, all taken modulo 2^16. For every other code `result` is 0.
- R3: With `flag_we` high, NOT, INC, ADD, SUB, AND and IADD set Z to (result == 0) and N to result bit 15 at the next edge.
- R4: With `flag_we` high, INC, ADD and IADD set C to the carry out of bit 15, and SUB sets C to 1 exactly when a < b as unsigned numbers. NOT and AND keep C.
- R5: SETC with `flag_we` high sets C to 1 and leaves Z and N unchanged.
- R6: NOP, PASS, JMP and untaken jumps change no flag. When `flag_we` is low and `restore_stb` is low, the flags do not change.
- R7: `branch_taken` is 1 for JMP, 1 for JZ/JN/JC when Z/N/C is currently 1, and 0 otherwise. `branch_target` always equals `op_a`.
- R8: A taken JZ, JN or JC with `flag_we` high clears the tested flag at the next edge and leaves the other two flags unchanged.
- R9: `save_stb` copies the flags as they stand before the edge into the shadow. `restore_stb` loads the shadow into the flags and takes priority over any flag update in the same cycle.
- R10: When `save_stb` and `restore_stb` are high in the same cycle, the flags and the shadow copy exchange their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | 16 | First operand and jump target |
| op_b | input | 16 | Second operand or immediate |
| op_sel | input | 4 | Operation code |
| flag_we | input | 1 | Allows the operation to update the flags |
| save_stb | input | 1 | Capture flags into the shadow copy |
| restore_stb | input | 1 | Load flags from the shadow copy |
| result | output | 16 | Operation result |
| flags | output | 3 | Current flags {C, N, Z} |
| branch_taken | output | 1 | Jump decision |
| branch_target | output | 16 | Jump destination |

## Verification
The functions that can collide are a flag-writing operation and an interrupt save or restore in the same cycle. The bench provokes this by asserting `save_stb` or `restore_stb` together with an ADD, a SETC or a taken jump that has `flag_we` high. It also asserts both strobes together. In each case the behavioural model predicts that the restore wins and that the shadow receives the flags as they stood before the edge. Every cycle is compared against that prediction, and a later restore exposes the shadow value through the flag outputs.

// File: rtl/alu_cc_pkg.sv
// Shared operation codes and flag bit positions for the ALU/condition-code unit.
package alu_cc_pkg;
    localparam int NFLAG = 3;
    localparam int FZ = 0;
    localparam int FN = 1;
    localparam int FC = 2;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_NOT  = 4'd1,
        OP_INC  = 4'd2,
        OP_ADD  = 4'd3,
        OP_SUB  = 4'd4,
        OP_AND  = 4'd5,
        OP_IADD = 4'd6,
        OP_PASS = 4'd7,
        OP_SETC = 4'd8,
        OP_JZ   = 4'd9,
        OP_JN   = 4'd10,
        OP_JC   = 4'd11,
        OP_JMP  = 4'd12
    } alu_op_e;
endpackage

// File: rtl/alu_cc_datapath.sv
// Arithmetic/logic datapath. Produces the result and, per flag bit, a write
// mask and the value to write. Assumes op_b already holds any immediate.
module alu_cc_datapath
    import alu_cc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic [3:0]       op_sel,
    output logic [W-1:0]     result,
    output logic [NFLAG-1:0] wr_mask,
    output logic [NFLAG-1:0] wr_val
);
    logic [W:0] sum_ext;
    logic [W:0] dif_ext;
    logic [W:0] inc_ext;
    logic       carry;
    logic       zn_upd;
    logic       c_upd;

    // Wide adders: bit W is carry out (sum/inc) or borrow (difference).
    always_comb begin
        sum_ext = {1'b0, op_a} + {1'b0, op_b};
        dif_ext = {1'b0, op_a} - {1'b0, op_b};
        inc_ext = {1'b0, op_a} + {{W{1'b0}}, 1'b1};
    end

    // Result select plus which flag groups the operation updates.
    always_comb begin
        result = '0;
        carry  = 1'b0;
        zn_upd = 1'b0;
        c_upd  = 1'b0;
        case (alu_op_e'(op_sel))
            OP_NOT:  begin result = ~op_a;          zn_upd = 1'b1; end
            OP_AND:  begin result = op_a & op_b;    zn_upd = 1'b1; end
            OP_INC:  begin result = inc_ext[W-1:0]; carry = inc_ext[W];
                           zn_upd = 1'b1; c_upd = 1'b1; end
            OP_ADD,
            OP_IADD: begin result = sum_ext[W-1:0]; carry = sum_ext[W];
                           zn_upd = 1'b1; c_upd = 1'b1; end
            OP_SUB:  begin result = dif_ext[W-1:0]; carry = dif_ext[W];
                           zn_upd = 1'b1; c_upd = 1'b1; end
            OP_PASS: result = op_a;
            OP_SETC: begin carry = 1'b1; c_upd = 1'b1; end
            default: result = '0;
        endcase
    end

    // Per-bit write mask and write value for the flag register.
    always_comb begin
        wr_mask     = '0;
        wr_val      = '0;
        wr_mask[FZ] = zn_upd;
        wr_mask[FN] = zn_upd;
        wr_mask[FC] = c_upd;
        wr_val[FZ]  = (result == '0);
        wr_val[FN]  = result[W-1];
        wr_val[FC]  = carry;
    end
endmodule

// File: rtl/alu_cc_branch.sv
// Jump evaluation. Decides the jump from the current flags and names the flag
// that a taken conditional jump must clear. The target is the register operand.
module alu_cc_branch
    import alu_cc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]     op_a,
    input  logic [3:0]       op_sel,
    input  logic [NFLAG-1:0] flags,
    output logic             taken,
    output logic [W-1:0]     target,
    output logic [NFLAG-1:0] clr_mask
);
    // Condition test and clear mask for the jump family.
    always_comb begin
        taken    = 1'b0;
        clr_mask = '0;
        case (alu_op_e'(op_sel))
            OP_JZ:   begin taken = flags[FZ]; clr_mask[FZ] = flags[FZ]; end
            OP_JN:   begin taken = flags[FN]; clr_mask[FN] = flags[FN]; end
            OP_JC:   begin taken = flags[FC]; clr_mask[FC] = flags[FC]; end
            OP_JMP:  taken = 1'b1;
            default: taken = 1'b0;
        endcase
    end

    // Target is always the register operand.
    assign target = op_a;
endmodule

// File: rtl/alu_cc_flagreg.sv
// Condition-code register plus interrupt shadow copy. Restore has priority
// over an operation's write. Save samples the pre-edge flags.
module alu_cc_flagreg
    import alu_cc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flag_we,
    input  logic             save_stb,
    input  logic             restore_stb,
    input  logic [NFLAG-1:0] wr_mask,
    input  logic [NFLAG-1:0] wr_val,
    input  logic [NFLAG-1:0] clr_mask,
    output logic [NFLAG-1:0] flags_q,
    output logic [NFLAG-1:0] shadow_q
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_bit
        logic f_q;
        logic s_q;

        // One flag bit and its shadow: restore, then write, then clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                f_q <= 1'b0;
                s_q <= 1'b0;
            end else begin
                if (restore_stb)
                    f_q <= s_q;
                else if (flag_we && wr_mask[i])
                    f_q <= wr_val[i];
                else if (flag_we && clr_mask[i])
                    f_q <= 1'b0;
                if (save_stb)
                    s_q <= f_q;
            end
        end

        assign flags_q[i]  = f_q;
        assign shadow_q[i] = s_q;
    end
endmodule

// File: rtl/alu_cc_unit.sv
// Top: execute-stage ALU with condition-code register and jump evaluation.
// Assumes the caller sequences save/restore strobes for interrupt entry/return.
module alu_cc_unit
    import alu_cc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   op_sel,
    input  logic         flag_we,
    input  logic         save_stb,
    input  logic         restore_stb,
    output logic [W-1:0] result,
    output logic [2:0]   flags,
    output logic         branch_taken,
    output logic [W-1:0] branch_target
);
    logic [NFLAG-1:0] wr_mask;
    logic [NFLAG-1:0] wr_val;
    logic [NFLAG-1:0] clr_mask;
    logic [NFLAG-1:0] shadow_flags;

    alu_cc_datapath #(.W(W)) u_dp (
        .op_a    (op_a),
        .op_b    (op_b),
        .op_sel  (op_sel),
        .result  (result),
        .wr_mask (wr_mask),
        .wr_val  (wr_val)
    );

    alu_cc_branch #(.W(W)) u_br (
        .op_a     (op_a),
        .op_sel   (op_sel),
        .flags    (flags),
        .taken    (branch_taken),
        .target   (branch_target),
        .clr_mask (clr_mask)
    );

    alu_cc_flagreg u_fr (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag_we     (flag_we),
        .save_stb    (save_stb),
        .restore_stb (restore_stb),
        .wr_mask     (wr_mask),
        .wr_val      (wr_val),
        .clr_mask    (clr_mask),
        .flags_q     (flags),
        .shadow_q    (shadow_flags)
    );
endmodule

// File: rtl/alu_cc_chk.sv
// Temporal checks on the ALU/condition-code unit, bound to the top module.
module alu_cc_chk
    import alu_cc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] op_sel,
    input logic       flag_we,
    input logic       save_stb,
    input logic       restore_stb,
    input logic [2:0] flags,
    input logic [2:0] shadow_flags,
    input logic       branch_taken
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (flags == 3'b000 && shadow_flags == 3'b000));

    // R6
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we && !restore_stb) |=> $stable(flags));

    // R5
    setc_only_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !restore_stb && op_sel == 4'd8)
        |=> (flags[FC] && flags[1:0] == $past(flags[1:0])));

    // R4
    logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !restore_stb && (op_sel == 4'd5 || op_sel == 4'd1))
        |=> (flags[FC] == $past(flags[FC])));

    // R7
    jmp_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd12) |-> branch_taken);

    // R7
    jc_follows_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd11) |-> (branch_taken == flags[FC]));

    // R8
    jz_clears_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !restore_stb && op_sel == 4'd9 && flags[FZ])
        |=> (!flags[FZ] && flags[2:1] == $past(flags[2:1])));

    // R9
    restore_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore_stb |=> (flags == $past(shadow_flags)));

    // R9
    save_captures_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_stb |=> (shadow_flags == $past(flags)));
endmodule

bind alu_cc_unit alu_cc_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_sel       (op_sel),
    .flag_we      (flag_we),
    .save_stb     (save_stb),
    .restore_stb  (restore_stb),
    .flags        (flags),
    .shadow_flags (shadow_flags),
    .branch_taken (branch_taken)
);

// File: tb/alu_cc_unit_test.sv
module alu_cc_unit_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] op_a, op_b;
    logic [3:0]  op_sel;
    logic        flag_we, save_stb, restore_stb;
    logic [15:0] result, branch_target;
    logic [2:0]  flags;
    logic        branch_taken;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural model state: flags as {C,N,Z}
    int m_z, m_n, m_c;
    int s_z, s_n, s_c;

    always #2 clk = ~clk;

    alu_cc_unit uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .flag_we(flag_we), .save_stb(save_stb), .restore_stb(restore_stb),
        .result(result), .flags(flags), .branch_taken(branch_taken),
        .branch_target(branch_target)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    function automatic int mflags();
        return m_c * 4 + m_n * 2 + m_z;
    endfunction

    // One cycle: drive after the falling edge, check combinational outputs,
    // advance the model on the rising edge.
    task automatic step(input int op, input int a, input int b, input bit we,
                        input bit sv, input bit rs, input string ftag);
        int er, ec, tk, wzn, wc, nz, nn, nc;
        @(negedge clk);
        check(ftag, "flags", flags, mflags());
        op_sel = op[3:0]; op_a = a[15:0]; op_b = b[15:0];
        flag_we = we; save_stb = sv; restore_stb = rs;
        er = 0; ec = 0; wzn = 0; wc = 0; tk = 0;
        case (op)
            1: begin er = (~a) & 'hFFFF; wzn = 1; end
            2: begin er = (a + 1) & 'hFFFF; ec = (a + 1) > 'hFFFF; wzn = 1; wc = 1; end
            3, 6: begin er = (a + b) & 'hFFFF; ec = (a + b) > 'hFFFF; wzn = 1; wc = 1; end
            4: begin er = (a - b) & 'hFFFF; ec = (a < b); wzn = 1; wc = 1; end
            5: begin er = a & b; wzn = 1; end
            7: er = a;
            8: begin ec = 1; wc = 1; end
            9:  tk = m_z;
            10: tk = m_n;
            11: tk = m_c;
            12: tk = 1;
            default: ;
        endcase
        #1;
        check("R2", "result", result, er);
        check("R7", "branch_taken", branch_taken, tk);
        check("R7", "branch_target", branch_target, a & 'hFFFF);
        nz = m_z; nn = m_n; nc = m_c;
        if (rs) begin
            nz = s_z; nn = s_n; nc = s_c;
        end else if (we) begin
            if (wzn) begin nz = (er == 0); nn = (er >= 'h8000); end
            if (wc) nc = ec;
            if (op == 9 && tk != 0) nz = 0;
            if (op == 10 && tk != 0) nn = 0;
            if (op == 11 && tk != 0) nc = 0;
        end
        @(posedge clk);
        if (sv) begin s_z = m_z; s_n = m_n; s_c = m_c; end
        m_z = nz; m_n = nn; m_c = nc;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; op_a = 0; op_b = 0; op_sel = 0;
        flag_we = 0; save_stb = 0; restore_stb = 0;
        m_z = 0; m_n = 0; m_c = 0; s_z = 0; s_n = 0; s_c = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset flags", flags, 0);
        rst_n = 1;
        // R3 R4 arithmetic and logical flag effects
        step(3, 'hFFFF, 1, 1, 0, 0, "R4");        // ADD wraps: Z=1 C=1
        step(5, 'h8000, 'hFFFF, 1, 0, 0, "R3");   // AND: N=1, C kept
        step(1, 'hFFFF, 0, 1, 0, 0, "R4");        // NOT -> 0, C kept
        step(4, 3, 5, 1, 0, 0, "R4");             // SUB borrow
        step(4, 5, 3, 1, 0, 0, "R4");             // SUB no borrow
        step(2, 'hFFFF, 0, 1, 0, 0, "R4");        // INC wrap
        step(2, 'h7FFF, 0, 1, 0, 0, "R3");        // INC to negative
        step(6, 'h1234, 'h0001, 1, 0, 0, "R3");   // IADD
        step(8, 0, 0, 1, 0, 0, "R5");             // SETC
        step(7, 'hABCD, 0, 1, 0, 0, "R6");        // PASS keeps flags
        step(3, 'hFFFF, 'hFFFF, 0, 0, 0, "R6");   // write disabled
        step(0, 0, 0, 1, 0, 0, "R6");             // NOP
        // R7 R8 jumps
        step(12, 'h0040, 0, 1, 0, 0, "R7");
        step(9, 'h0100, 0, 1, 0, 0, "R8");        // JZ untaken
        step(11, 'h0200, 0, 1, 0, 0, "R8");       // JC taken clears C
        step(4, 0, 1, 1, 0, 0, "R4");             // N=1 C=1
        step(10, 'h0300, 0, 1, 0, 0, "R8");       // JN taken clears N
        step(3, 0, 0, 1, 0, 0, "R3");             // Z=1
        step(9, 'h0400, 0, 1, 0, 0, "R8");        // JZ taken clears Z
        // R9 save/restore and collisions
        step(4, 0, 1, 1, 1, 0, "R9");             // save with SUB in same cycle
        step(8, 0, 0, 1, 0, 0, "R9");
        step(3, 1, 1, 1, 0, 1, "R9");             // restore beats ADD
        step(8, 0, 0, 1, 1, 0, "R9");             // save pre-SETC flags
        step(0, 0, 0, 0, 0, 1, "R9");
        step(3, 0, 0, 1, 0, 0, "R10");
        step(0, 0, 0, 1, 1, 1, "R10");            // swap
        step(0, 0, 0, 0, 0, 1, "R10");            // shadow now visible
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 15);
            step(op, $urandom_range(0, 'hFFFF), $urandom_range(0, 'hFFFF),
                 $urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0,
                 $urandom_range(0, 7) == 0, "R3");
        end
        @(negedge clk);
        check("R3", "final flags", flags, mflags());
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule